// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit register file and a data memory whose bus is one 32-bit word wide. A request carries a byte address, an access size (byte, halfword or word), a write flag and, for stores, the register value. On the next clock the block presents a word-aligned bus address. It also presents a per-lane byte-enable mask and write data placed on the lanes that the access covers.

When a load's data word comes back from memory, the block selects the addressed byte or halfword. It extends the value to the full 32 bits, with sign or zero fill, and presents the result one clock later. An access whose address does not suit its size raises a one-cycle fault flag instead of reaching the bus.

A parameter picks the byte numbering. With little-endian numbering the lowest address inside a word is the least significant lane. With big-endian numbering it is the most significant lane. Address generation, the memory array, the register file and fault handling are left to neighbouring logic.

Top module: `mem_lane_align`

## Requirements
- R1: An aligned request accepted on a clock edge drives `bus_valid` high after that edge. `bus_addr` equals the request address with its two low bits cleared, and `bus_we` equals the request's write flag.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. A request faults in any of these cases: a halfword at an odd address, a word whose address bits [1:0] are not 00, or the reserved size. A faulting request raises `fault` for one cycle, leaves `bus_valid` low and `bus_be` at 0000, and issues no access.
- R3: Byte enables with little-endian numbering: a byte at offset o sets bit o, a halfword at offset o sets bits o and o+1, and a word sets 1111. With big-endian numbering: a byte at offset o sets bit 3-o, a halfword sets 1100 at offset 0 and 0011 at offset 2, and a word sets 1111.
- R4: Store data is taken from the low end of the source register. A byte store puts bits [7:0] on all four lanes, a halfword store puts bits [15:0] on both halves, and a word store passes all 32 bits unchanged.
- R5: A signed byte or halfword load fills every result bit above the loaded value with that value's top bit.
- R6: An unsigned byte or halfword load fills every result bit above the loaded value with zero.
- R7: Load lane selection: with little-endian numbering a byte at offset o comes from bus bits [8o+7:8o] and a halfword from bits [8o+15:8o]. With big-endian numbering a byte comes from lane 3-o and a halfword from lanes 3-o and 2-o. A word load returns the bus word unchanged.
- R8: `ld_valid` rises for one cycle after `rsp_valid`, only when an aligned load was issued and not yet answered. A response that follows a faulted load produces no `ld_valid`.
- R9: While `rst` is high, every output is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Load extension: 1 zero fill, 0 sign fill |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Register value to store |
| rsp_valid | input | 1 | Memory returns read data |
| rsp_rdata | input | 32 | Returned bus word |
| bus_valid | output | 1 | Bus access issued |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Per-lane byte enables |
| bus_wdata | output | 32 | Lane-placed write data |
| fault | output | 1 | Misaligned or reserved-size request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
On every cycle the assertions check several relations. A fault never coincides with a bus access or any enabled lane. The number of enabled lanes matches the size that was requested. A misaligned word request is always followed by a fault. A load result only follows a response. Byte load results carry the correct upper fill. The exact lane picked for each offset under both byte numberings can only be shown by the bench's scenarios, which run a little-endian and a big-endian instance side by side. The same holds for the replicated store data and for the suppression of a response that follows a faulted load.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // number of bytes moved by an access of the given size
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 1;
      SZ_HALF: size_bytes = 2;
      default: size_bytes = 4;
    endcase
  endfunction

endpackage

// File: rtl/lane_fault_check.sv
module lane_fault_check #(
  parameter int OFF_W = 2
) (
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] off,
  output logic             misaligned
);
  import lane_align_pkg::*;

  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = off[0];
      SZ_WORD: misaligned = |off[1:0];
      default: misaligned = 1'b1;
    endcase
  end

endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [1:0]                     size,
  input  logic [$clog2(DATA_W/8)-1:0]    off,
  input  logic [DATA_W-1:0]              src,
  output logic [DATA_W/8-1:0]            be,
  output logic [DATA_W-1:0]              lanes
);
  import lane_align_pkg::*;

  localparam int NLANE = DATA_W / 8;
  localparam int OFF_W = $clog2(NLANE);

  int unsigned      nbytes;
  logic [OFF_W-1:0] base;
  logic [NLANE-1:0] mask;

  assign nbytes = size_bytes(size);

  generate
    if (BIG_ENDIAN) begin : g_big
      // lowest address lands on the most significant covered lane
      assign base = OFF_W'(NLANE - nbytes - 32'(off));
    end else begin : g_little
      assign base = off;
    end
  endgenerate

  assign mask = NLANE'((32'd1 << nbytes) - 32'd1);
  assign be   = mask << base;

  // replicate the low-order source bytes across the lanes
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: lanes[8*i +: 8] = src[7:0];
        SZ_HALF: lanes[8*i +: 8] = src[8*(i%2) +: 8];
        default: lanes[8*i +: 8] = src[8*i +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lane_load_unpack.sv
module lane_load_unpack #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [1:0]                  size,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic                        uns,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           result
);
  import lane_align_pkg::*;

  localparam int NLANE = DATA_W / 8;
  localparam int OFF_W = $clog2(NLANE);

  int unsigned       nbytes;
  logic [OFF_W-1:0]  base;
  logic [DATA_W-1:0] shifted;
  logic              fill;

  assign nbytes = size_bytes(size);

  generate
    if (BIG_ENDIAN) begin : g_big
      assign base = OFF_W'(NLANE - nbytes - 32'(off));
    end else begin : g_little
      assign base = off;
    end
  endgenerate

  assign shifted = rdata >> {base, 3'b000};

  always_comb begin
    fill = 1'b0;
    case (size)
      SZ_BYTE: begin
        fill   = ~uns & shifted[7];
        result = {{(DATA_W-8){fill}}, shifted[7:0]};
      end
      SZ_HALF: begin
        fill   = ~uns & shifted[15];
        result = {{(DATA_W-16){fill}}, shifted[15:0]};
      end
      default: result = shifted;
    endcase
  end

endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                rsp_valid,
  input  logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_valid,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                fault,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data
);
  import lane_align_pkg::*;

  localparam int NLANE = DATA_W / 8;
  localparam int OFF_W = $clog2(NLANE);

  logic [OFF_W-1:0]  req_off;
  logic              mis;
  logic              issue;
  logic [NLANE-1:0]  be_c;
  logic [DATA_W-1:0] lanes_c;
  logic [DATA_W-1:0] unpack_c;

  logic              pend_flag;
  logic [OFF_W-1:0]  pend_off;
  logic [1:0]        pend_size;
  logic              pend_uns;

  assign req_off = req_addr[OFF_W-1:0];
  assign issue   = req_valid & ~mis;

  lane_fault_check #(.OFF_W(OFF_W)) u_check (
    .size       (req_size),
    .off        (req_off),
    .misaligned (mis)
  );

  lane_store_pack #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_pack (
    .size  (req_size),
    .off   (req_off),
    .src   (req_wdata),
    .be    (be_c),
    .lanes (lanes_c)
  );

  lane_load_unpack #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_unpack (
    .size   (pend_size),
    .off    (pend_off),
    .uns    (pend_uns),
    .rdata  (rsp_rdata),
    .result (unpack_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      fault     <= 1'b0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      pend_flag <= 1'b0;
      pend_off  <= '0;
      pend_size <= 2'b00;
      pend_uns  <= 1'b0;
    end else begin
      bus_valid <= issue;
      bus_we    <= issue & req_write;
      bus_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      bus_be    <= issue ? be_c : '0;
      bus_wdata <= lanes_c;
      fault     <= req_valid & mis;

      ld_valid  <= rsp_valid & pend_flag;
      if (rsp_valid & pend_flag) ld_data <= unpack_c;

      if (rsp_valid) pend_flag <= 1'b0;
      if (issue & ~req_write) begin
        pend_flag <= 1'b1;
        pend_off  <= req_off;
        pend_size <= req_size;
        pend_uns  <= req_unsigned;
      end
    end
  end

  // R1: a bus access only follows an accepted request
  p_access_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> $past(req_valid));

  // R2: a fault never reaches the bus
  p_fault_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    fault |-> (bus_be == '0) && !bus_valid);

  // R2: a misaligned word request must fault
  p_word_mis_faults_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_size) == SZ_WORD && $past(req_addr[1:0]) != 2'b00)
      |-> fault);

  // R3: the number of enabled lanes matches the requested size
  p_lane_count_r3: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ($countones(bus_be) == (1 << $past(req_size))));

  // R8: a load result only follows a memory response
  p_ld_after_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(rsp_valid));

  // R5: signed byte loads carry the sign upward
  p_byte_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !$past(pend_uns) && $past(pend_size) == SZ_BYTE)
      |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));

  // R6: unsigned byte loads carry zeros upward
  p_byte_zext_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && $past(pend_uns) && $past(pend_size) == SZ_BYTE)
      |-> (ld_data[DATA_W-1:8] == '0));

endmodule

// File: tb/mem_lane_align_tb.sv
module mem_lane_align_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  logic        le_bv, le_we, le_fault, le_lv;
  logic [31:0] le_addr, le_wd, le_ld;
  logic [3:0]  le_be;
  logic        be_bv, be_we, be_fault, be_lv;
  logic [31:0] be_addr, be_wd, be_ld;
  logic [3:0]  be_be;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mem_lane_align #(.BIG_ENDIAN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_valid(le_bv), .bus_we(le_we), .bus_addr(le_addr), .bus_be(le_be),
    .bus_wdata(le_wd), .fault(le_fault), .ld_valid(le_lv), .ld_data(le_ld));

  mem_lane_align #(.BIG_ENDIAN(1'b1)) u_dut_be (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_valid(be_bv), .bus_we(be_we), .bus_addr(be_addr), .bus_be(be_be),
    .bus_wdata(be_wd), .fault(be_fault), .ld_valid(be_lv), .ld_data(be_ld));

  typedef struct {
    bit          is_load;
    bit          flt;
    bit          we;
    logic [31:0] addr;
    logic [3:0]  be_le;
    logic [3:0]  be_be;
    logic [31:0] wdata;
    logic [31:0] ld_le;
    logic [31:0] ld_be;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] extend(input logic [31:0] v, input logic [1:0] sz,
                                         input logic uns);
    if (sz == 2'b00) return uns ? {24'h0, v[7:0]} : {{24{v[7]}}, v[7:0]};
    if (sz == 2'b01) return uns ? {16'h0, v[15:0]} : {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  // Driver: issue one access and push what must appear
  task automatic op(input logic wr, input logic [1:0] sz, input logic uns,
                    input logic [31:0] a, input logic [31:0] wd,
                    input logic [31:0] rd, input string tag);
    exp_t e;
    int   o;
    bit   mis;
    o   = int'(a[1:0]);
    mis = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    e.is_load = 1'b0;
    e.flt  = mis;
    e.we   = wr;
    e.addr = {a[31:2], 2'b00};
    e.tag  = tag;
    case (sz)
      2'b00: begin e.be_le = 4'b0001 << o; e.be_be = 4'b1000 >> o; e.wdata = {4{wd[7:0]}}; end
      2'b01: begin e.be_le = 4'b0011 << o; e.be_be = (o == 0) ? 4'b1100 : 4'b0011;
                   e.wdata = {2{wd[15:0]}}; end
      default: begin e.be_le = 4'hF; e.be_be = 4'hF; e.wdata = wd; end
    endcase
    if (mis) begin e.be_le = 4'h0; e.be_be = 4'h0; end
    e.ld_le = '0;
    e.ld_be = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = uns;
    req_addr = a; req_wdata = wd;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      rsp_valid = 1'b1;
      rsp_rdata = rd;
      if (!mis) begin
        exp_t l;
        l = e;
        l.is_load = 1'b1;
        l.ld_le = extend(rd >> (8 * o), sz, uns);
        if (sz == 2'b00)      l.ld_be = extend(rd >> (8 * (3 - o)), sz, uns);
        else if (sz == 2'b01) l.ld_be = extend(rd >> (8 * (2 - o)), sz, uns);
        else                  l.ld_be = rd;
        sb.push_back(l);
      end
      @(negedge clk);
      rsp_valid = 1'b0;
      if (mis) begin
        check(!le_lv, {"R8 no result after faulted load LE ", tag}, 32'(le_lv), 0);
        check(!be_lv, {"R8 no result after faulted load BE ", tag}, 32'(be_lv), 0);
      end
    end
    @(negedge clk);
  endtask

  // Monitor: compare outputs as they appear
  always @(posedge clk) begin
    #1;
    if (!rst && (le_bv || le_fault || le_lv || be_bv || be_fault || be_lv)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected output", {29'h0, le_bv, le_fault, le_lv}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (!e.is_load) begin
          check(le_fault == e.flt && be_fault == e.flt, {"R2 fault ", e.tag},
                32'(le_fault), 32'(e.flt));
          check(le_bv == !e.flt && be_bv == !e.flt, {"R1 bus_valid ", e.tag},
                32'(le_bv), 32'(!e.flt));
          check(le_be == e.be_le, {"R3 be LE ", e.tag}, 32'(le_be), 32'(e.be_le));
          check(be_be == e.be_be, {"R3 be BE ", e.tag}, 32'(be_be), 32'(e.be_be));
          if (!e.flt) begin
            check(le_addr == e.addr && be_addr == e.addr, {"R1 addr ", e.tag},
                  le_addr, e.addr);
            check(le_we == e.we && be_we == e.we, {"R1 we ", e.tag}, 32'(le_we), 32'(e.we));
            if (e.we) begin
              check(le_wd == e.wdata, {"R4 wdata LE ", e.tag}, le_wd, e.wdata);
              check(be_wd == e.wdata, {"R4 wdata BE ", e.tag}, be_wd, e.wdata);
            end
          end
        end else begin
          check(le_lv && be_lv, {"R8 ld_valid ", e.tag}, 32'(le_lv), 1);
          check(le_ld == e.ld_le, {"R7 load LE ", e.tag}, le_ld, e.ld_le);
          check(be_ld == e.ld_be, {"R7 load BE ", e.tag}, be_ld, e.ld_be);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({le_bv, le_we, le_be, le_fault, le_lv} == '0 && le_addr == 0 && le_wd == 0
          && le_ld == 0, "R9 reset LE", {le_bv, le_fault, le_lv, le_be}, 0);
    check({be_bv, be_we, be_be, be_fault, be_lv} == '0 && be_addr == 0 && be_wd == 0
          && be_ld == 0, "R9 reset BE", {be_bv, be_fault, be_lv, be_be}, 0);
    rst = 1'b0;
    @(negedge clk);

    // stores, every byte offset, both halfword slots, word
    for (int i = 0; i < 4; i++)
      op(1'b1, 2'b00, 1'b0, 32'h1000_0100 + 32'(i), 32'hCAFE_BEA5, '0, "R3 R4 byte store");
    op(1'b1, 2'b01, 1'b0, 32'hFFFF_FFF0, 32'h1234_A5C3, '0, "R3 R4 half store off0");
    op(1'b1, 2'b01, 1'b0, 32'hFFFF_FFF2, 32'h1234_A5C3, '0, "R3 R4 half store off2");
    op(1'b1, 2'b10, 1'b0, 32'h0000_0008, 32'hDEAD_BEEF, '0, "R1 R4 word store");

    // misaligned and reserved requests
    op(1'b1, 2'b01, 1'b0, 32'h0000_0011, 32'h1111_2222, '0, "R2 half off1");
    op(1'b1, 2'b01, 1'b0, 32'h0000_0013, 32'h1111_2222, '0, "R2 half off3");
    for (int i = 1; i < 4; i++)
      op(1'b1, 2'b10, 1'b0, 32'h0000_0020 + 32'(i), 32'h3333_4444, '0, "R2 word misaligned");
    op(1'b1, 2'b11, 1'b0, 32'h0000_0040, 32'h5555_6666, '0, "R2 reserved size");

    // loads: signed and unsigned bytes on every lane
    for (int i = 0; i < 4; i++) begin
      op(1'b0, 2'b00, 1'b0, 32'h2000_0000 + 32'(i), '0, 32'h80FF_7F01, "R5 R7 signed byte");
      op(1'b0, 2'b00, 1'b1, 32'h2000_0000 + 32'(i), '0, 32'h80FF_7F01, "R6 R7 unsigned byte");
    end
    // halfwords on both slots, two patterns
    op(1'b0, 2'b01, 1'b0, 32'h2000_0004, '0, 32'h7FFE_8001, "R5 R7 signed half off0");
    op(1'b0, 2'b01, 1'b0, 32'h2000_0006, '0, 32'h7FFE_8001, "R5 R7 signed half off2");
    op(1'b0, 2'b01, 1'b1, 32'h2000_0004, '0, 32'h9ABC_F00D, "R6 R7 unsigned half off0");
    op(1'b0, 2'b01, 1'b1, 32'h2000_0006, '0, 32'h9ABC_F00D, "R6 R7 unsigned half off2");
    op(1'b0, 2'b01, 1'b0, 32'h2000_0006, '0, 32'h9ABC_F00D, "R5 signed half negative");
    op(1'b0, 2'b10, 1'b0, 32'h2000_000C, '0, 32'h8765_4321, "R7 word load");

    // faulted loads: the later response must be dropped
    op(1'b0, 2'b10, 1'b0, 32'h2000_0002, '0, 32'hFFFF_FFFF, "R8 faulted word load");
    op(1'b0, 2'b01, 1'b1, 32'h2000_0001, '0, 32'hFFFF_FFFF, "R8 faulted half load");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8 all expected outputs seen", 32'(sb.size()), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule